// File: doc/BRIEF.md
# Audio Codec Serial Transceiver

This block drives the clocking of a stereo audio codec and carries 20-bit samples to and from it over single-wire serial data lines. A single sequence counter, running on the system clock, sets every timing relationship: the codec master clock is the system clock itself. The serial bit clock is one quarter of that rate. A left/right select flips at the end of every channel window, and the bit index and the sub-bit phase are read straight out of the counter.

In each channel window the first 80 clocks carry one 20-bit word in each direction, most significant bit first, and the rest of the window is idle. Transmit words come from two parallel inputs, one per channel, and are captured into a shadow register on the clock edge that opens the window. Received words are collected from the serial input and presented on per-channel output registers. A one-clock strobe marks the end of every stereo frame's right-channel word.

Top module: `codec_serial_xcvr`

## Requirements
- R1: The channel window lasts CHAN_CLKS clocks (a parameter limited to 128, 192 or 256, default 128). `lrsel` is 0 in a left window and 1 in a right window, and it inverts on the edge after the last clock of each window.
- R2: `rst_n` is an active-low reset, sampled on the rising clock edge. While it is applied, `bit_idx`, `phase`, `lrsel`, `sdout`, `rx_left`, `rx_right` and `rx_valid` all read 0, and the transmit shadow is cleared.
- R3: `mclk` follows `clk`. `bclk` is low in phases 0 and 1 and high in phases 2 and 3, so it has a period of four clocks.
- R4: `phase` counts 0,1,2,3 once per clock. `bit_idx` goes up by one each time `phase` wraps to 0 and returns to 0 at the start of every window.
- R5: While `bit_idx` b is below 20, `sdout` holds bit 19-b of the captured word for all four phases. It therefore changes only when `phase` is 0.
- R6: While `bit_idx` is 20 or more, `sdout` is 0.
- R7: The word sent in a window is taken from `tx_left` (left window) or `tx_right` (right window) on the edge that opens the window. Changes to those inputs during the window have no effect on `sdout`. The first window after reset sends all zeros.
- R8: `sdin` is sampled on the rising edge at which `phase` is 2 and `bit_idx` is below 20, and the samples are assembled MSB first. Its value at phases 0, 1 and 3 is ignored.
- R9: The word is complete on the phase-2 edge of bit 19. From the next clock it appears on `rx_left` if `lrsel` is 0 or on `rx_right` if `lrsel` is 1, and the other register keeps its value.
- R10: `rx_valid` is high for exactly one clock per frame: phase 3 of bit 19 in the right window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the codec master clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| tx_left | input | 20 | Left-channel word to transmit |
| tx_right | input | 20 | Right-channel word to transmit |
| sdin | input | 1 | Serial data from the codec |
| mclk | output | 1 | Master clock to the codec |
| bclk | output | 1 | Serial bit clock, one quarter rate |
| lrsel | output | 1 | Channel select, 0 left, 1 right |
| sdout | output | 1 | Serial data to the codec |
| bit_idx | output | 6 | Bit position within the current window |
| phase | output | 2 | Sub-phase within the current bit |
| rx_left | output | 20 | Last received left word |
| rx_right | output | 20 | Last received right word |
| rx_valid | output | 1 | One-clock strobe after a right word completes |

## Verification
The hardest situation to reach is a transmit input that changes in the middle of a window it must not affect, together with a serial input that is valid only at the sampling phase. Driving a correct word alone would not show that the capture point and the idle tail are right. The stimulus therefore changes the transmit inputs at random clocks inside windows and drives random values on `sdin` in every phase except phase 2. It also applies a reset in the middle of a frame, then checks that the frame restarts in a left window and sends zeros. Directed words with all ones, a single set bit and alternating bits are mixed in so that bit order errors show up.

// File: rtl/codec_xcvr_pkg.sv
// Package: shared types and parameter checks for the codec serial transceiver.
// Assumes: the channel window is one of the three lengths the codec accepts.
package codec_xcvr_pkg;

    // Channel carried in the current window; the encoding is visible on lrsel.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Number of serial sub-phases per data bit.
    localparam int PHASES_PER_BIT = 4;

    // True when the window length is one the codec supports.
    function automatic bit window_len_ok(input int n);
        return (n == 128) || (n == 192) || (n == 256);
    endfunction

endpackage

// File: rtl/codec_seq_timer.sv
// Module: sequence counter for the codec frame.
// Counts clocks within a channel window, flips the channel at the window end
// and decodes bit index, phase and bit clock from the count.
// Assumes: CHAN_CLKS is a multiple of four and IDX_W holds CHAN_CLKS/4-1.
module codec_seq_timer
    import codec_xcvr_pkg::*;
#(
    parameter int CHAN_CLKS = 128,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] bit_idx,
    output logic [1:0]       phase,
    output logic             bclk,
    output chan_e            chan,
    output logic             win_last
);

    localparam int              CNT_W = $clog2(CHAN_CLKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAN_CLKS - 1);

    logic [CNT_W-1:0] seq;

    // Advance the count and toggle the channel when the window ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq  <= '0;
            chan <= CH_LEFT;
        end else if (seq == LAST) begin
            seq  <= '0;
            chan <= (chan == CH_LEFT) ? CH_RIGHT : CH_LEFT;
        end else begin
            seq  <= seq + 1'b1;
        end
    end

    // Decode position outputs from the count.
    always_comb begin
        phase    = seq[1:0];
        bclk     = seq[1];
        bit_idx  = IDX_W'(seq >> 2);
        win_last = (seq == LAST);
    end

endmodule

// File: rtl/codec_tx_serializer.sv
// Module: transmit shadow and MSB-first serializer.
// Captures the next channel's word on the last clock of a window and shifts
// one bit per four clocks; the line is low after the last data bit.
// Assumes: win_last, phase and bit_idx come from the shared sequence counter.
module codec_tx_serializer
    import codec_xcvr_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_last,
    input  chan_e               chan,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [1:0]          phase,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sdout
);

    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] shadow;
    logic                in_word;

    assign in_word = (bit_idx <= LAST_BIT);

    // Load the word for the next window, else shift after each data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (win_last) begin
            shadow <= (chan == CH_LEFT) ? tx_right : tx_left;
        end else if (in_word && phase == 2'd3) begin
            shadow <= {shadow[SAMPLE_W-2:0], 1'b0};
        end
    end

    // Present the current MSB during the data bits, low when idle.
    always_comb begin
        sdout = in_word ? shadow[SAMPLE_W-1] : 1'b0;
    end

endmodule

// File: rtl/codec_rx_deserializer.sv
// Module: receive shifter and per-channel output registers.
// Samples the serial input at phase 2 of each data bit, MSB first, and moves
// the finished word to the register of the current channel.
// Assumes: phase and bit_idx come from the shared sequence counter.
module codec_rx_deserializer
    import codec_xcvr_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdin,
    input  chan_e               chan,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic [1:0]          phase,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(SAMPLE_W - 1);
    localparam int               NCHAN    = 2;

    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] next_word;
    logic                take;
    logic                word_done;
    logic [SAMPLE_W-1:0] rx_word [NCHAN];

    // Decode sampling points and the word formed by the current bit.
    always_comb begin
        take      = (phase == 2'd2) && (bit_idx <= LAST_BIT);
        word_done = (phase == 2'd2) && (bit_idx == LAST_BIT);
        next_word = {shreg[SAMPLE_W-2:0], sdin};
    end

    // Shift in one serial bit at each sampling point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (take) begin
            shreg <= next_word;
        end
    end

    // One output register per channel, written when its word completes.
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_word[c] <= '0;
            end else if (word_done && chan == chan_e'(1'(c))) begin
                rx_word[c] <= next_word;
            end
        end
    end

    // Strobe once the right-channel word of a frame is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= word_done && (chan == CH_RIGHT);
        end
    end

    assign rx_left  = rx_word[0];
    assign rx_right = rx_word[1];

endmodule

// File: rtl/codec_serial_xcvr.sv
// Module: top of the audio codec serial transceiver.
// Generates codec clocks and channel select from one counter and moves one
// word per channel window in each direction.
// Assumes: the codec runs from mclk and uses the same channel window length.
module codec_serial_xcvr
    import codec_xcvr_pkg::*;
#(
    parameter int CHAN_CLKS = 128,
    parameter int SAMPLE_W  = 20,
    parameter int IDX_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    input  logic                sdin,
    output logic                mclk,
    output logic                bclk,
    output logic                lrsel,
    output logic                sdout,
    output logic [IDX_W-1:0]    bit_idx,
    output logic [1:0]          phase,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    localparam int CNT_W = $clog2(CHAN_CLKS);

    // Reject parameter sets the codec or the counter cannot support.
    if (!window_len_ok(CHAN_CLKS)) begin : g_bad_len
        $error("CHAN_CLKS must be 128, 192 or 256");
    end
    if (SAMPLE_W * PHASES_PER_BIT > CHAN_CLKS) begin : g_bad_width
        $error("SAMPLE_W does not fit the channel window");
    end
    if (IDX_W < CNT_W - 2) begin : g_bad_idx
        $error("IDX_W too narrow for the bit index");
    end

    chan_e chan;
    logic  win_last;

    codec_seq_timer #(
        .CHAN_CLKS (CHAN_CLKS),
        .IDX_W     (IDX_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_idx  (bit_idx),
        .phase    (phase),
        .bclk     (bclk),
        .chan     (chan),
        .win_last (win_last)
    );

    codec_tx_serializer #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_last (win_last),
        .chan     (chan),
        .bit_idx  (bit_idx),
        .phase    (phase),
        .tx_left  (tx_left),
        .tx_right (tx_right),
        .sdout    (sdout)
    );

    codec_rx_deserializer #(
        .SAMPLE_W (SAMPLE_W),
        .IDX_W    (IDX_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdin     (sdin),
        .chan     (chan),
        .bit_idx  (bit_idx),
        .phase    (phase),
        .rx_left  (rx_left),
        .rx_right (rx_right),
        .rx_valid (rx_valid)
    );

    assign mclk  = clk;
    assign lrsel = chan;

endmodule

// File: rtl/codec_xcvr_chk.sv
// Module: timing checker for the codec serial transceiver, bound to the top.
// Assumes: reset is held for at least one clock edge after time zero.
module codec_xcvr_chk #(
    parameter int CHAN_CLKS = 128,
    parameter int SAMPLE_W  = 20,
    parameter int IDX_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lrsel,
    input logic             bclk,
    input logic             sdout,
    input logic             rx_valid,
    input logic [IDX_W-1:0] bit_idx,
    input logic [1:0]       phase
);

    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(SAMPLE_W - 1);
    localparam logic [IDX_W-1:0] MAX_IDX  = IDX_W'(CHAN_CLKS / 4 - 1);

    p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase == $past(phase) + 2'd1);

    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= MAX_IDX);

    p_bclk_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> $past(phase) == 2'd1);

    p_lr_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrsel) |-> (bit_idx == '0 && phase == 2'd0));

    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx > LAST_BIT) |-> !sdout);

    p_tx_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdout) && bit_idx <= LAST_BIT) |-> phase == 2'd0);

    p_valid_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (lrsel && bit_idx == LAST_BIT && phase == 2'd3));

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind codec_serial_xcvr codec_xcvr_chk #(
    .CHAN_CLKS (CHAN_CLKS),
    .SAMPLE_W  (SAMPLE_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lrsel    (lrsel),
    .bclk     (bclk),
    .sdout    (sdout),
    .rx_valid (rx_valid),
    .bit_idx  (bit_idx),
    .phase    (phase)
);

// File: tb/sim_codec_serial_xcvr.sv
module sim_codec_serial_xcvr;

    localparam int CH = 128;
    localparam int W  = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tx_left = '0;
    logic [W-1:0] tx_right = '0;
    logic         sdin = 1'b0;
    logic         mclk, bclk, lrsel, sdout, rx_valid;
    logic [5:0]   bit_idx;
    logic [1:0]   phase;
    logic [W-1:0] rx_left, rx_right;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    int           k;
    logic [W-1:0] shadow;
    logic [W-1:0] rxw [2];
    logic [W-1:0] exp_rx [2];
    logic [W-1:0] dir_words [4] = '{20'hFFFFF, 20'h00001, 20'hAAAAA, 20'h80000};
    int           win_count;

    codec_serial_xcvr #(.CHAN_CLKS(CH), .SAMPLE_W(W), .IDX_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_left(tx_left), .tx_right(tx_right),
        .sdin(sdin), .mclk(mclk), .bclk(bclk), .lrsel(lrsel), .sdout(sdout),
        .bit_idx(bit_idx), .phase(phase), .rx_left(rx_left),
        .rx_right(rx_right), .rx_valid(rx_valid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (k=%0d)", req, act, exp, k);
        end
    endtask

    function automatic logic exp_sdout(input int seq, input logic [W-1:0] word);
        int b = seq / 4;
        return (b < W) ? word[W-1-b] : 1'b0;
    endfunction

    task automatic check_reset_state();
        chk("R2 bit_idx", 32'(bit_idx), 0);
        chk("R2 phase", 32'(phase), 0);
        chk("R2 lrsel", 32'(lrsel), 0);
        chk("R2 sdout", 32'(sdout), 0);
        chk("R2 rx_left", 32'(rx_left), 0);
        chk("R2 rx_right", 32'(rx_right), 0);
        chk("R2 rx_valid", 32'(rx_valid), 0);
    endtask

    // Compare every output against the model for position k (at negedge).
    task automatic check_state();
        int seq = k % CH;
        int lr  = (k / CH) % 2;
        int b   = seq / 4;
        int ph  = seq % 4;
        chk("R4 bit_idx", 32'(bit_idx), 32'(b));
        chk("R4 phase", 32'(phase), 32'(ph));
        chk("R1 lrsel", 32'(lrsel), 32'(lr));
        chk("R3 bclk", 32'(bclk), 32'(ph >= 2));
        chk("R3 mclk", 32'(mclk), 32'(clk));
        if (b < W) chk("R5 R7 sdout", 32'(sdout), 32'(exp_sdout(seq, shadow)));
        else       chk("R6 sdout idle", 32'(sdout), 0);
        chk("R9 rx_left", 32'(rx_left), 32'(exp_rx[0]));
        chk("R9 rx_right", 32'(rx_right), 32'(exp_rx[1]));
        chk("R10 rx_valid", 32'(rx_valid), 32'(seq == 19*4 + 3 && lr == 1));
    endtask

    // Drive inputs for the next edge, then advance the model across it.
    task automatic step();
        int seq = k % CH;
        int lr  = (k / CH) % 2;
        int b   = seq / 4;
        int ph  = seq % 4;
        // R8: correct bit only at phase 2, noise elsewhere
        if (ph == 2 && b < W) sdin = rxw[lr][W-1-b];
        else                  sdin = 1'($urandom);
        // R7: random mid-window changes of the transmit inputs
        if (($urandom % 16) == 0) tx_left  = W'($urandom);
        if (($urandom % 16) == 0) tx_right = W'($urandom);
        if (seq == CH - 1 && win_count < 4) begin
            if (lr == 0) tx_right = dir_words[win_count];
            else         tx_left  = dir_words[win_count];
        end
        @(posedge clk);
        if (seq == 19*4 + 2) exp_rx[lr] = rxw[lr];
        if (seq == CH - 1) begin
            shadow = (lr == 0) ? tx_right : tx_left;
            rxw[1-lr] = (win_count < 4) ? ~dir_words[win_count] : W'($urandom);
            win_count++;
        end
        k++;
        @(negedge clk);
    endtask

    task automatic model_restart();
        k = 0;
        shadow = '0;
        exp_rx[0] = '0;
        exp_rx[1] = '0;
        rxw[0] = W'($urandom);
        rxw[1] = W'($urandom);
    endtask

    initial begin
        void'($urandom(32'd1234));
        win_count = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        model_restart();
        rst_n = 1'b1;
        for (int i = 0; i < 8 * CH + 37; i++) begin
            check_state();
            step();
        end
        // Mid-frame reset
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();
        model_restart();
        win_count = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 6 * CH; i++) begin
            check_state();
            step();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule